// File: doc/BRIEF.md
# Virtualization CSR Bank Swapper

This block keeps the supervisor trap and address-translation state for a core that runs a hypervisor. It has one live register set that the core reads and writes, and two saved banks: one for the host supervisor and one for the guest (virtual) supervisor. The live set holds seven registers: trap vector, scratch, exception PC, cause, trap value, translation pointer and status.

Just before the core flips its virtualization mode bit, it pulses a swap strobe and presents the current mode. The live registers are then saved into the bank of the mode being left, and refilled from the bank of the mode being entered. The status register is not copied whole. Only a fixed subset of its bits moves between the live register and the banks, and every other live status bit keeps its value.

The swap takes effect on the clock edge that samples the strobe, and a one-cycle ready pulse follows. A swap requested while the hypervisor extension is disabled is refused: an error pulse is raised and no state changes. A CSR write that arrives together with a strobe is held off, and the requester must retry it.

Top module: `csr_bank_swap`

## Requirements
- R1: After reset, every live and banked register reads zero, and `ready_o` and `err_o` are low.
- R2: On a legal swap with `virt_i`=1, the six non-status live registers are copied into the virtual bank, and the live registers are loaded from the host bank, all on the same edge.
- R3: On a legal swap with `virt_i`=0, the six non-status live registers are copied into the host bank, and the live registers are loaded from the virtual bank.
- R4: The status swap mask has bit 1, bit 5, bit 8, bits 14:13, bit 18 and bit 19 set, and also bits 33:32 when XLEN=64. On a swap, the saving bank's status becomes (live AND mask). The live status becomes (live AND NOT mask) OR (status of the loading bank).
- R5: A swap leaves the live status bits outside the mask unchanged. A status write into either bank keeps only the masked bits, and the other bits read back as zero.
- R6: A swap strobe with `hyp_en_i`=0 raises `err_o` in the next cycle and changes no register. `ready_o` stays low.
- R7: `ready_o` is high for exactly the one cycle after a legal swap edge, and low otherwise.
- R8: While `swap_i` is high, a write request raises `wr_stall_o` and is not applied. The same write repeated after the strobe drops is applied on top of the swapped state.
- R9: Bank codes are 0 for live, 1 for host and 2 for virtual; code 3 selects nothing. Register indexes are 0 for status, 1 for trap vector, 2 for scratch, 3 for exception PC, 4 for cause, 5 for trap value and 6 for translation pointer. A write is visible on `rd_data_o` from the cycle after its edge. Reads of code 3, or of an index above 6, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hyp_en_i | input | 1 | Hypervisor extension enabled |
| swap_i | input | 1 | Swap strobe, one cycle |
| virt_i | input | 1 | Current virtualization mode, before the flip |
| wr_en_i | input | 1 | CSR write request |
| wr_bank_i | input | 2 | Target set of the write (0 live, 1 host, 2 virtual) |
| wr_sel_i | input | 3 | Register index of the write |
| wr_data_i | input | XLEN | Write data |
| wr_stall_o | output | 1 | Write held off by a concurrent swap |
| rd_bank_i | input | 2 | Set to read |
| rd_sel_i | input | 3 | Register index to read |
| rd_data_o | output | XLEN | Read data (combinational) |
| ready_o | output | 1 | Swap completed in the previous cycle |
| err_o | output | 1 | Illegal swap was requested in the previous cycle |

## Verification
The bench builds the block with XLEN=64, its default. This brings the two extra mask bits at positions 33:32 into reach, so the status checks cover both the low and the upper mask fields. Live status words with all bits set show that the bits outside the mask survive a swap. The bench swaps in both directions, one after another, and checks every register in all three sets after each swap. It also issues a refused swap and a write that collides with a strobe.

// File: rtl/csr_swap_pkg.sv
`timescale 1ns/1ps
package csr_swap_pkg;
  localparam int NREG = 7;
  localparam int SELW = 3;

  typedef enum logic [1:0] {
    BK_LIVE = 2'd0,
    BK_HOST = 2'd1,
    BK_VIRT = 2'd2,
    BK_NONE = 2'd3
  } bank_e;

  localparam int IDX_STATUS = 0;

  // bits of the status word that move between the live set and a bank
  function automatic logic [63:0] status_mask(input int xlen);
    logic [63:0] m;
    m = '0;
    m[1]     = 1'b1;
    m[5]     = 1'b1;
    m[8]     = 1'b1;
    m[14:13] = 2'b11;
    m[18]    = 1'b1;
    m[19]    = 1'b1;
    if (xlen == 64) m[33:32] = 2'b11;
    return m;
  endfunction
endpackage

// File: rtl/csr_swap_bank.sv
`timescale 1ns/1ps
module csr_swap_bank
  import csr_swap_pkg::*;
#(
  parameter int          XLEN    = 64,
  parameter logic [XLEN-1:0] ST_MASK = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       save_i,
  input  logic [NREG-1:0][XLEN-1:0]  save_data_i,
  input  logic                       wr_en_i,
  input  logic [SELW-1:0]            wr_sel_i,
  input  logic [XLEN-1:0]            wr_data_i,
  output logic [NREG-1:0][XLEN-1:0]  data_o
);
  logic [NREG-1:0][XLEN-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (save_i) begin
      for (int k = 0; k < NREG; k++) begin
        if (k == IDX_STATUS) data_q[k] <= save_data_i[k] & ST_MASK;
        else                 data_q[k] <= save_data_i[k];
      end
    end else if (wr_en_i && (int'(wr_sel_i) < NREG)) begin
      if (int'(wr_sel_i) == IDX_STATUS) data_q[wr_sel_i] <= wr_data_i & ST_MASK;
      else                              data_q[wr_sel_i] <= wr_data_i;
    end
  end

  assign data_o = data_q;

  AST_BANK_SAVE_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |=> data_o[IDX_STATUS] == ($past(save_data_i[IDX_STATUS]) & ST_MASK)); // R4
  AST_BANK_SAVE_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |=> data_o[3] == $past(save_data_i[3])); // R2
endmodule

// File: rtl/csr_swap_live.sv
`timescale 1ns/1ps
module csr_swap_live
  import csr_swap_pkg::*;
#(
  parameter int          XLEN    = 64,
  parameter logic [XLEN-1:0] ST_MASK = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [NREG-1:0][XLEN-1:0]  load_data_i,
  input  logic                       wr_en_i,
  input  logic [SELW-1:0]            wr_sel_i,
  input  logic [XLEN-1:0]            wr_data_i,
  output logic [NREG-1:0][XLEN-1:0]  data_o
);
  logic [NREG-1:0][XLEN-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (load_i) begin
      for (int k = 0; k < NREG; k++) begin
        if (k == IDX_STATUS) data_q[k] <= (data_q[k] & ~ST_MASK) | load_data_i[k];
        else                 data_q[k] <= load_data_i[k];
      end
    end else if (wr_en_i && (int'(wr_sel_i) < NREG)) begin
      data_q[wr_sel_i] <= wr_data_i;
    end
  end

  assign data_o = data_q;

  AST_LIVE_KEEP_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (data_o[IDX_STATUS] & ~ST_MASK) == $past(data_o[IDX_STATUS] & ~ST_MASK)); // R5
endmodule

// File: rtl/csr_bank_swap.sv
`timescale 1ns/1ps
module csr_bank_swap
  import csr_swap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hyp_en_i,
  input  logic              swap_i,
  input  logic              virt_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_bank_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [XLEN-1:0]   wr_data_i,
  output logic              wr_stall_o,
  input  logic [1:0]        rd_bank_i,
  input  logic [2:0]        rd_sel_i,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              ready_o,
  output logic              err_o
);
  localparam logic [63:0]     FULL_MASK = status_mask(XLEN);
  localparam logic [XLEN-1:0] ST_MASK   = FULL_MASK[XLEN-1:0];

  logic swap_ok, swap_bad, wr_go;
  logic ready_q, err_q;
  logic [NREG-1:0][XLEN-1:0] live_data;
  logic [1:0][NREG-1:0][XLEN-1:0] bank_data; // [0] host, [1] virtual

  assign swap_ok    = swap_i & hyp_en_i;
  assign swap_bad   = swap_i & ~hyp_en_i;
  assign wr_go      = wr_en_i & ~swap_i;
  assign wr_stall_o = wr_en_i & swap_i;

  csr_swap_live #(.XLEN(XLEN), .ST_MASK(ST_MASK)) u_live (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (swap_ok),
    .load_data_i (bank_data[~virt_i]),
    .wr_en_i     (wr_go && (wr_bank_i == BK_LIVE)),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .data_o      (live_data)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic [1:0] ID = (b == 0) ? BK_HOST : BK_VIRT;
    csr_swap_bank #(.XLEN(XLEN), .ST_MASK(ST_MASK)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .save_i      (swap_ok && (virt_i == b[0])),
      .save_data_i (live_data),
      .wr_en_i     (wr_go && (wr_bank_i == ID)),
      .wr_sel_i    (wr_sel_i),
      .wr_data_i   (wr_data_i),
      .data_o      (bank_data[b])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_sel_i) < NREG) begin
      case (rd_bank_i)
        BK_LIVE: rd_data_o = live_data[rd_sel_i];
        BK_HOST: rd_data_o = bank_data[0][rd_sel_i];
        BK_VIRT: rd_data_o = bank_data[1][rd_sel_i];
        default: rd_data_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ready_q <= swap_ok;
      err_q   <= swap_bad;
    end
  end

  assign ready_o = ready_q;
  assign err_o   = err_q;

  AST_READY_AFTER_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_ok |=> ready_o && !err_o); // R7
  AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_bad |=> err_o && !ready_o && $stable(live_data) && $stable(bank_data)); // R6
  AST_LOAD_FROM_HOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_ok && virt_i) |=> live_data[1] == $past(bank_data[0][1])); // R2
  AST_LOAD_FROM_VIRT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_ok && !virt_i) |=> live_data[1] == $past(bank_data[1][1])); // R3
  AST_STALL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stall_o && !hyp_en_i) |=> $stable(live_data)); // R8
endmodule

// File: tb/sim_csr_bank_swap.sv
`timescale 1ns/1ps
module sim_csr_bank_swap;
  localparam int XLEN = 64;
  localparam logic [63:0] MASK = 64'h0000_0003_000C_6122;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hyp_en = 1'b0, swap = 1'b0, virt = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_bank = '0, rd_bank = '0;
  logic [2:0] wr_sel = '0, rd_sel = '0;
  logic [63:0] wr_data = '0;
  logic wr_stall, ready, err;
  logic [63:0] rd_data;

  int checks = 0;
  int failures = 0;
  logic [63:0] m [3][7];

  always #4 clk = ~clk;

  csr_bank_swap #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hyp_en_i(hyp_en), .swap_i(swap), .virt_i(virt),
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .wr_stall_o(wr_stall), .rd_bank_i(rd_bank), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .ready_o(ready), .err_o(err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 7; s++) begin
        rd_bank = 2'(b); rd_sel = 3'(s); #0.2;
        chk(req, rd_data, m[b][s]);
      end
  endtask

  task automatic do_write(input int b, input int s, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 2'(b); wr_sel = 3'(s); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m[b][s] = (b != 0 && s == 0) ? (d & MASK) : d;
  endtask

  function automatic void model_swap(input logic v);
    int src, dst;
    logic [63:0] old;
    src = v ? 1 : 2;
    dst = v ? 2 : 1;
    for (int s = 1; s < 7; s++) begin
      m[dst][s] = m[0][s];
      m[0][s]   = m[src][s];
    end
    old = m[0][0];
    m[dst][0] = old & MASK;
    m[0][0]   = (old & ~MASK) | m[src][0];
  endfunction

  task automatic do_swap(input logic v, input logic hyp, input string req);
    @(negedge clk);
    swap = 1'b1; virt = v; hyp_en = hyp;
    @(posedge clk); #1;
    chk({req, " R7 ready"}, 64'(ready), 64'(hyp));
    chk({req, " R6 err"}, 64'(err), 64'(!hyp));
    @(negedge clk);
    swap = 1'b0; hyp_en = 1'b1;
    @(posedge clk); #1;
    chk("R7 ready one cycle", 64'(ready), 64'd0);
    chk("R6 err one cycle", 64'(err), 64'd0);
    if (hyp) model_swap(v);
  endtask

  task automatic t_reset;
    chk("R1 ready", 64'(ready), 64'd0);
    chk("R1 err", 64'(err), 64'd0);
    check_all("R1 reset zero");
  endtask

  task automatic t_fill;
    for (int s = 0; s < 7; s++) begin
      do_write(0, s, 64'hA5A5_0000_0000_1000 + 64'(s));
      do_write(1, s, 64'hFFFF_FFFF_FFFF_FFFF - 64'(s));
      do_write(2, s, 64'h3C3C_0000_0000_2000 + 64'(s * 3));
    end
    check_all("R9 R5 fill readback");
  endtask

  task automatic t_swap_to_virt;
    do_swap(1'b0, 1'b1, "R3 R4 swap V=0");
    check_all("R3 R4 after swap V=0");
  endtask

  task automatic t_swap_to_host;
    do_swap(1'b1, 1'b1, "R2 R4 swap V=1");
    check_all("R2 R4 after swap V=1");
  endtask

  task automatic t_illegal;
    do_swap(1'b0, 1'b0, "R6 illegal");
    check_all("R6 no change");
  endtask

  task automatic t_collide;
    @(negedge clk);
    swap = 1'b1; virt = 1'b0; hyp_en = 1'b1;
    wr_en = 1'b1; wr_bank = 2'd0; wr_sel = 3'd2; wr_data = 64'hDEAD_BEEF_0000_0042;
    #1;
    chk("R8 stall high", 64'(wr_stall), 64'd1);
    @(negedge clk);
    swap = 1'b0;
    model_swap(1'b0);
    #1;
    chk("R8 stall low", 64'(wr_stall), 64'd0);
    rd_bank = 2'd0; rd_sel = 3'd2; #0.2;
    chk("R8 write not applied", rd_data, m[0][2]);
    @(negedge clk);
    wr_en = 1'b0;
    m[0][2] = 64'hDEAD_BEEF_0000_0042;
    check_all("R8 retried write");
  endtask

  task automatic t_unmasked;
    do_write(0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    do_write(2, 0, 64'h0);
    do_swap(1'b0, 1'b1, "R5 swap");
    chk("R5 live status", m[0][0], 64'hFFFF_FFFC_FFF3_9EDD);
    check_all("R5 unmasked kept");
    rd_bank = 2'd0; rd_sel = 3'd0; #0.2;
    chk("R5 live status port", rd_data, 64'hFFFF_FFFC_FFF3_9EDD);
  endtask

  task automatic t_bad_select;
    rd_bank = 2'd3; rd_sel = 3'd1; #0.2;
    chk("R9 code 3 reads zero", rd_data, 64'd0);
    rd_bank = 2'd0; rd_sel = 3'd7; #0.2;
    chk("R9 index 7 reads zero", rd_data, 64'd0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 7; s++) m[b][s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hyp_en = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_swap_to_virt();
    t_swap_to_host();
    t_illegal();
    t_collide();
    t_unmasked();
    t_bad_select();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule